// File: doc/BRIEF.md
# Ramped Two-Channel Digital Volume

This block applies a linear digital gain to a stereo stream of 24-bit signed samples. Each channel has its own 8-bit target level. The gain used on a sample is the applied level divided by 255. Level 255 passes the sample unchanged, and level 0 silences the channel. The applied level does not jump to a new target. It moves one unit at a time, and it moves only on step ticks. A step tick comes once every 4, 8 or 16 frames, chosen by the speed mode. A full sweep over the 255 units therefore takes 1020, 2040 or 4080 frames.

A mute request sets the goal of both channels to zero, so each applied level slides down at the stepping rate. If the request is dropped, each level climbs back to its own target at the same rate. This holds even when the level had not yet reached zero. One frame-step counter paces both channels. Each channel still keeps its own applied level.

A new stereo pair is presented together with a one-cycle frame strobe. The scaled pair appears on the outputs one clock later and holds until the next strobe.

Top module: `ramp_volume`

## Requirements
- R1: After a synchronous reset, both outputs are 0 and both applied levels are 255. The first frame after reset is passed through unchanged.
- R2: On each frame strobe, each output is loaded with (sample × applied level) / 255, truncated toward zero. This holds for the extreme samples 0x800000 and 0x7FFFFF.
- R3: With speed mode 0, the applied level changes only on every 4th frame strobe, and by exactly one unit.
- R4: With speed mode 1, the applied level steps once every 8 frames. With speed mode 2, it steps once every 16 frames. Speed mode 3 behaves like mode 2.
- R5: While the mute request is high, each applied level falls by one unit per step tick until it reaches 0. After that the outputs are 0.
- R6: When the mute request is dropped, each applied level rises toward its target at the same rate. This includes a release partway down the ramp. With target 255 the output again equals the input.
- R7: When a target level changes without mute, the applied level moves toward it in either direction by one unit per step tick. It stops at the target.
- R8: The two channels follow their own targets independently and share only the step timing.
- R9: The outputs change only in the cycle after a frame strobe. Sample inputs that change without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe marking a valid sample pair |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| left_level | input | 8 | Left target level (0 = silent, 255 = unity) |
| right_level | input | 8 | Right target level |
| mute_req | input | 1 | Soft-mute request for both channels |
| speed_sel | input | 2 | Step spacing: 0 = 4 frames, 1 = 8 frames, 2 or 3 = 16 frames |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |

## Verification
The reference model is driven with these patterns:
- **Extreme and rotating samples:** a sample stream that rotates through full-scale positive, full-scale negative, small negative values and pseudo-random values. This separates truncation toward zero from flooring, and it exposes overflow in the product.
- **Opposite-direction ramps:** the two channels ramp in opposite directions at the same time. This shows whether the channels are kept apart.
- **Mute held to the end:** a mute is held until both levels reach silence. This exercises a full ramp down.
- **Mute released early:** a mute is released partway down. This checks that the ramp turns back rather than jumping.
- **Mute in every speed mode:** the mute sweep is repeated in each speed mode. This tells the 4-, 8- and 16-frame step spacings apart.
- **Samples changed without a strobe:** longer gaps between strobes, with the samples changed inside the gaps, show whether unstrobed data leaks through.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int SAMPLE_W = 24;
  localparam int LEVEL_W  = 8;
  localparam int BASE_FRAMES = 4;
  localparam int MAX_SHIFT   = 2;
  localparam int MAX_PERIOD  = BASE_FRAMES << MAX_SHIFT;
  localparam int CNT_W       = $clog2(MAX_PERIOD + 1);

  // frames between level steps for a given speed code
  function automatic logic [CNT_W-1:0] frames_per_step(input logic [1:0] spd);
    int sh;
    sh = (int'(spd) > MAX_SHIFT) ? MAX_SHIFT : int'(spd);
    return CNT_W'(BASE_FRAMES << sh);
  endfunction
endpackage

// File: rtl/vol_step_timer.sv
module vol_step_timer
  import vol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic [1:0] speed_sel,
  output logic       step_tick
);
  logic [CNT_W-1:0] frame_cnt;
  logic [CNT_W-1:0] last_idx;

  assign last_idx  = frames_per_step(speed_sel) - CNT_W'(1);
  assign step_tick = frame_stb && (frame_cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst)            frame_cnt <= '0;
    else if (step_tick) frame_cnt <= '0;
    else if (frame_stb) frame_cnt <= frame_cnt + CNT_W'(1);
  end

  // R4: the frame count stays inside the longest step period
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    frame_cnt < CNT_W'(MAX_PERIOD));
  // R3: the counter never moves without a frame strobe
  a_r3_count_on_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(frame_cnt));
endmodule

// File: rtl/vol_level_ramp.sv
module vol_level_ramp
  import vol_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               step_tick,
  input  logic               mute_req,
  input  logic [LEVEL_W-1:0] target,
  output logic [LEVEL_W-1:0] level
);
  logic [LEVEL_W-1:0] goal;

  assign goal = mute_req ? '0 : target;

  always_ff @(posedge clk) begin
    if (rst) level <= '1;
    else if (step_tick) begin
      if (level < goal)      level <= level + LEVEL_W'(1);
      else if (level > goal) level <= level - LEVEL_W'(1);
    end
  end

  // R7: every change of the level is a single unit
  a_r7_unit_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |->
      (({1'b0, level} == {1'b0, $past(level)} + 9'd1) ||
       ({1'b0, level} + 9'd1 == {1'b0, $past(level)})));
  // R3: the level moves only after a step tick
  a_r3_tick_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> $past(step_tick));
  // R5: under mute the level never rises
  a_r5_mute_no_rise: assert property (@(posedge clk) disable iff (rst)
    mute_req |=> (level <= $past(level)));
endmodule

// File: rtl/vol_gain_mult.sv
module vol_gain_mult
  import vol_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_stb,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [LEVEL_W-1:0]         level,
  output logic signed [SAMPLE_W-1:0] scaled
);
  localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
  localparam logic signed [PROD_W-1:0] FULL = PROD_W'(255);

  logic signed [PROD_W-1:0] product;
  logic signed [PROD_W-1:0] quotient;

  assign product  = PROD_W'(sample) * PROD_W'($signed({1'b0, level}));
  assign quotient = product / FULL;

  always_ff @(posedge clk) begin
    if (rst)            scaled <= '0;
    else if (frame_stb) scaled <= quotient[SAMPLE_W-1:0];
  end

  // R9: no strobe, no output change
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(scaled));
  // R5: a silent level gives a silent output
  a_r5_zero_level: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && level == '0) |=> (scaled == '0));
endmodule

// File: rtl/ramp_volume.sv
module ramp_volume
  import vol_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_stb,
  input  logic signed [SAMPLE_W-1:0] left_in,
  input  logic signed [SAMPLE_W-1:0] right_in,
  input  logic [LEVEL_W-1:0]         left_level,
  input  logic [LEVEL_W-1:0]         right_level,
  input  logic                       mute_req,
  input  logic [1:0]                 speed_sel,
  output logic signed [SAMPLE_W-1:0] left_out,
  output logic signed [SAMPLE_W-1:0] right_out
);
  localparam int NCH = 2;

  logic                step_tick;
  logic [SAMPLE_W-1:0] ch_in   [NCH];
  logic [LEVEL_W-1:0]  ch_tgt  [NCH];
  logic [LEVEL_W-1:0]  ch_lvl  [NCH];
  logic [SAMPLE_W-1:0] ch_out  [NCH];

  assign ch_in[0]  = left_in;
  assign ch_in[1]  = right_in;
  assign ch_tgt[0] = left_level;
  assign ch_tgt[1] = right_level;
  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  vol_step_timer u_timer (
    .clk(clk), .rst(rst), .frame_stb(frame_stb),
    .speed_sel(speed_sel), .step_tick(step_tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vol_level_ramp u_ramp (
      .clk(clk), .rst(rst), .step_tick(step_tick), .mute_req(mute_req),
      .target(ch_tgt[c]), .level(ch_lvl[c])
    );
    vol_gain_mult u_mult (
      .clk(clk), .rst(rst), .frame_stb(frame_stb),
      .sample(ch_in[c]), .level(ch_lvl[c]), .scaled(ch_out[c])
    );
  end
endmodule

// File: tb/sim_ramp_volume.sv
`timescale 1ns/1ps
module sim_ramp_volume;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic signed [23:0] left_in = '0, right_in = '0;
  logic [7:0] left_level = 8'hFF, right_level = 8'hFF;
  logic mute_req = 1'b0;
  logic [1:0] speed_sel = 2'd0;
  logic signed [23:0] left_out, right_out;

  always #10 clk = ~clk;

  ramp_volume u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb),
    .left_in(left_in), .right_in(right_in),
    .left_level(left_level), .right_level(right_level),
    .mute_req(mute_req), .speed_sel(speed_sel),
    .left_out(left_out), .right_out(right_out)
  );

  int checks = 0, failures = 0;
  string phase = "R1";
  int m_lvl [2];
  int m_out [2];
  int m_cnt;
  int seed = 12345;
  bit done = 0;

  // behavioural reference, updated at the same edge the design uses
  always @(posedge clk) begin
    int per, goal, tgt;
    if (rst) begin
      m_lvl[0] = 255; m_lvl[1] = 255; m_out[0] = 0; m_out[1] = 0; m_cnt = 0;
    end else if (frame_stb) begin
      m_out[0] = int'(left_in)  * m_lvl[0] / 255;
      m_out[1] = int'(right_in) * m_lvl[1] / 255;
      per = (speed_sel == 2'd0) ? 4 : (speed_sel == 2'd1) ? 8 : 16;
      if (m_cnt >= per - 1) begin
        m_cnt = 0;
        for (int c = 0; c < 2; c++) begin
          tgt  = (c == 0) ? int'(left_level) : int'(right_level);
          goal = mute_req ? 0 : tgt;
          if (m_lvl[c] < goal) m_lvl[c]++;
          else if (m_lvl[c] > goal) m_lvl[c]--;
        end
      end else m_cnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      check(phase, int'(left_out),  m_out[0]);
      check(phase, int'(right_out), m_out[1]);
    end
  end

  function automatic logic signed [23:0] pick(int i);
    seed = seed * 1103515245 + 12345;
    case (i % 5)
      0: return 24'sh800000;
      1: return 24'sh7FFFFF;
      2: return -24'sd1 - 24'(i % 300);
      default: return 24'(seed >>> 5);
    endcase
  endfunction

  task automatic frames(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      left_in = pick(i); right_in = pick(i + 2);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      for (int g = 0; g < gap; g++) begin
        left_in = pick(i + 7); right_in = pick(i + 3);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1", int'(left_out), 0);
    check("R1", int'(right_out), 0);
    rst = 1'b0;
    @(negedge clk);
    left_in = 24'sh123456; right_in = -24'sd777; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    check("R1", int'(left_out), 'h123456);
    check("R1", int'(right_out), -777);
    phase = "R2"; left_level = 8'h80; right_level = 8'h81;
    frames(600, 0);
    phase = "R7"; left_level = 8'hF0; right_level = 8'h10;
    frames(1000, 0);
    phase = "R3"; left_level = 8'hFF;
    frames(100, 0);
    phase = "R8"; right_level = 8'h00; left_level = 8'hC0;
    frames(300, 0);
    phase = "R5"; left_level = 8'hFF; right_level = 8'hFF; mute_req = 1'b1;
    frames(1100, 0);
    @(negedge clk); left_in = 24'sh7FFFFF; right_in = 24'sh800000; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    check("R5", int'(left_out), 0);
    check("R5", int'(right_out), 0);
    phase = "R6"; mute_req = 1'b0;
    frames(200, 0);
    mute_req = 1'b1; frames(80, 0);
    mute_req = 1'b0; frames(1100, 0);
    @(negedge clk); left_in = 24'sh654321; right_in = -24'sd4242; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
    check("R6", int'(left_out), 'h654321);
    check("R6", int'(right_out), -4242);
    phase = "R4"; speed_sel = 2'd1; mute_req = 1'b1;
    frames(2100, 0);
    check("R4", m_lvl[0], 0);
    mute_req = 1'b0; speed_sel = 2'd2; frames(300, 0);
    mute_req = 1'b1; frames(4200, 0);
    check("R4", m_lvl[1], 0);
    mute_req = 1'b0; speed_sel = 2'd3; frames(400, 0);
    phase = "R9"; speed_sel = 2'd0; left_level = 8'h33;
    frames(300, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule